// File: doc/BRIEF.md
# Serial Transmitter with Line-Break Sequencing

This block serialises bytes onto a single line using asynchronous character framing: a low start bit, five to eight data bits sent least significant first, an optional parity bit and one or two high stop bits. Bit timing comes from an external one-cycle strobe, so every bit lasts exactly one strobe interval. A one-byte holding stage sits in front of the shift stage, which lets software-side logic queue the next byte while the current one is on the line. Two status flags tell the feeding logic when a byte can be accepted and when the line has gone completely quiet.

Besides characters, the transmitter can put a break on the line, meaning a low level that lasts at least one character frame. Start-break and stop-break commands drive this. A break behaves like a queued character: it waits for any character in flight, holds the line low for at least a frame, and then keeps the line high for a fixed guard interval so a receiver can see the break end. While this sequence runs, the block ignores commands and writes that would corrupt it.

Top module: `uart_break_tx`

## Requirements
- R1: After reset, the serial output is high and both the ready flag and the empty flag read 1.
- R2: A written byte is sent as one low start bit, then data bits LSB first, where data-size code 0/1/2/3 selects 5/6/7/8 bits. Parity code 1 adds a bit that makes the count of ones even, code 2 adds a bit that makes it odd, and codes 0 and 3 add none. Then come 1 stop bit, or 2 when the two-stop input is 1. Each bit lasts one strobe interval, and a byte queued during a frame follows with no idle gap.
- R3: The framing configuration is captured when a frame is loaded into the shift stage. Changing the inputs during a frame has no effect on that frame.
- R4: A start-break command is accepted only while ready is 1 and no break is pending, active or in its guard. Otherwise it is ignored.
- R5: An accepted start-break drops ready until the break begins. A character already shifting out completes, stop bits included, before the line goes low. Empty reads 0 from the first low bit onward.
- R6: The low time of a break is one frame length for the current configuration when stop-break arrives early. When stop-break arrives later, the low time ends at the first bit boundary after the stop.
- R7: After the low time, the line stays high for exactly 12 bit intervals. The empty flag returns to 1 at the end of that interval.
- R8: A stop-break command with no break in progress is ignored.
- R9: A byte written while a break is pending (ready 0) is discarded and never sent.
- R10: A byte written during the low time or the guard interval is discarded and never sent, although ready reads 1.
- R11: Start-break and stop-break given in the same cycle are both ignored.
- R12: A start-break given during an active break or its guard interval starts no second break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle strobe marking each bit boundary |
| wrEn | input | 1 | Write strobe for the holding stage |
| wrData | input | 8 | Byte to transmit |
| brkStart | input | 1 | Start-break command |
| brkStop | input | 1 | Stop-break command |
| cfgDataSel | input | 2 | Data size code (0..3 gives 5..8 bits) |
| cfgParity | input | 2 | Parity code (1 even, 2 odd, 0/3 none) |
| cfgTwoStop | input | 1 | Two stop bits when 1 |
| txd | output | 1 | Serial line, high when idle |
| txReady | output | 1 | Holding stage can take a byte |
| txEmpty | output | 1 | No byte, character or break remains |

## Verification
A wrong break state shows up on the serial line within one bit interval: a low run that is one bit too short or too long, a guard of eleven or thirteen high bits, or a stray frame after the guard when a write that should have been discarded leaks into the holding stage. A flag that does not match the state appears in the very next cycle after a command. The bench therefore logs the line once per bit and compares exact run lengths and decoded frames against values it computes from the configuration.

// File: rtl/ubk_pkg.sv
package ubk_pkg;
  localparam int DATA_MAX  = 8;
  localparam int STOP_MAX  = 2;
  localparam int FRAME_MAX = 1 + DATA_MAX + 1 + STOP_MAX;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef struct packed {
    logic [1:0] dataSel;
    logic [1:0] parity;
    logic       twoStop;
  } txCfg_t;

  // control -> datapath strobes
  typedef struct packed {
    logic acceptWr;
    logic blockLoad;
    logic forceLow;
  } dpCtrl_t;

  // datapath -> control status
  typedef struct packed {
    logic busy;
    logic holdFull;
    logic lastBit;
  } dpStat_t;

  typedef enum logic [1:0] {BIDLE, BPEND, BLOW, BGUARD} brkState_e;

  function automatic logic [CNT_W-1:0] frameLen(input txCfg_t c);
    logic [CNT_W-1:0] len;
    len = CNT_W'(6) + CNT_W'(c.dataSel)
        + ((c.parity == 2'd1 || c.parity == 2'd2) ? CNT_W'(1) : CNT_W'(0))
        + (c.twoStop ? CNT_W'(2) : CNT_W'(1));
    return len;
  endfunction

  function automatic logic [FRAME_MAX-1:0] buildFrame(input txCfg_t c,
                                                      input logic [DATA_MAX-1:0] d);
    logic [FRAME_MAX-1:0] f;
    logic pb;
    int n;
    f = '1;
    f[0] = 1'b0;
    pb = 1'b0;
    n = 5 + int'(c.dataSel);
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < n) begin
        f[1+i] = d[i];
        pb ^= d[i];
      end
    end
    if (c.parity == 2'd1) f[1+n] = pb;
    else if (c.parity == 2'd2) f[1+n] = ~pb;
    return f;
  endfunction
endpackage

// File: rtl/ubk_datapath.sv
module ubk_datapath
  import ubk_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitTick,
  input  logic [DATA_MAX-1:0] wrData,
  input  txCfg_t              cfg,
  input  dpCtrl_t             ctl,
  output dpStat_t             stat,
  output logic                txd
);
  logic [DATA_MAX-1:0]  holdReg;
  logic                 holdFull;
  logic [FRAME_MAX-1:0] shiftReg;
  logic [CNT_W-1:0]     bitsLeft;
  logic                 busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      shiftReg <= '1;
      bitsLeft <= '0;
      busy     <= 1'b0;
    end else begin
      if (ctl.acceptWr) begin
        holdReg  <= wrData;
        holdFull <= 1'b1;
      end
      if (bitTick) begin
        if (busy && bitsLeft > CNT_W'(1)) begin
          shiftReg <= {1'b1, shiftReg[FRAME_MAX-1:1]};
          bitsLeft <= bitsLeft - CNT_W'(1);
        end else if (holdFull && !ctl.blockLoad) begin
          shiftReg <= buildFrame(cfg, holdReg);
          bitsLeft <= frameLen(cfg);
          busy     <= 1'b1;
          holdFull <= 1'b0;
        end else begin
          busy     <= 1'b0;
          bitsLeft <= '0;
        end
      end
    end
  end

  assign stat.busy     = busy;
  assign stat.holdFull = holdFull;
  assign stat.lastBit  = busy && (bitsLeft == CNT_W'(1));
  assign txd = ctl.forceLow ? 1'b0 : (busy ? shiftReg[0] : 1'b1);

  // R2: a frame only starts on a bit boundary
  a_r2_load_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(bitTick));
  // R9: no frame is loaded while the break sequencer holds the shifter
  a_r9_no_load_blocked: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(ctl.blockLoad));
endmodule

// File: rtl/ubk_ctrl.sv
module ubk_ctrl
  import ubk_pkg::*;
#(
  parameter int GUARD_BITS = 12
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitTick,
  input  logic    wrEn,
  input  logic    cmdStart,
  input  logic    cmdStop,
  input  txCfg_t  cfg,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    txReady,
  output logic    txEmpty
);
  localparam int GW = $clog2(GUARD_BITS + 1);

  brkState_e        state;
  logic [CNT_W-1:0] lowLeft;
  logic [GW-1:0]    guardLeft;
  logic             stopSeen;
  logic             startOk, stopOk, shifterFree;

  always_comb begin
    txReady      = !stat.holdFull && (state != BPEND);
    startOk      = cmdStart && !cmdStop && txReady && (state == BIDLE);
    stopOk       = cmdStop && !cmdStart && txReady && (state == BLOW);
    shifterFree  = !stat.busy || stat.lastBit;
    ctl.acceptWr  = wrEn && (state == BIDLE) && !stat.holdFull && !startOk;
    ctl.blockLoad = (state != BIDLE);
    ctl.forceLow  = (state == BLOW);
    txEmpty = !stat.busy && !stat.holdFull && (state == BIDLE || state == BPEND);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= BIDLE;
      lowLeft   <= '0;
      guardLeft <= '0;
      stopSeen  <= 1'b0;
    end else begin
      unique case (state)
        BIDLE: if (startOk) state <= BPEND;
        BPEND: if (bitTick && shifterFree) begin
          state    <= BLOW;
          lowLeft  <= frameLen(cfg);
          stopSeen <= 1'b0;
        end
        BLOW: begin
          if (stopOk) stopSeen <= 1'b1;
          if (bitTick) begin
            if (lowLeft > CNT_W'(1)) lowLeft <= lowLeft - CNT_W'(1);
            else begin
              lowLeft <= '0;
              if (stopSeen || stopOk) begin
                state     <= BGUARD;
                guardLeft <= GW'(GUARD_BITS);
              end
            end
          end
        end
        BGUARD: if (bitTick) begin
          if (guardLeft > GW'(1)) guardLeft <= guardLeft - GW'(1);
          else state <= BIDLE;
        end
        default: state <= BIDLE;
      endcase
    end
  end

  // R4: a full holding stage blocks a start-break
  a_r4_full_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == BIDLE && stat.holdFull) |=> state != BPEND);
  // R5: the line is only forced low once the shift stage is empty
  a_r5_low_shifter_idle: assert property (@(posedge clk) disable iff (!rstN)
    state == BLOW |-> !stat.busy);
  // R6: the low phase is left only after its frame count ran out
  a_r6_min_low: assert property (@(posedge clk) disable iff (!rstN)
    (state == BGUARD && $past(state) == BLOW) |-> $past(lowLeft) <= CNT_W'(1));
  // R7: nothing shifts during the guard interval
  a_r7_guard_quiet: assert property (@(posedge clk) disable iff (!rstN)
    state == BGUARD |-> !stat.busy);
  // R10: writes never reach the holding stage during low time or guard
  a_r10_no_hold_in_break: assert property (@(posedge clk) disable iff (!rstN)
    (state == BLOW || state == BGUARD) |-> !stat.holdFull);
  // R12: an active break can only move on to its guard
  a_r12_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    state == BLOW |=> (state == BLOW || state == BGUARD));
endmodule

// File: rtl/uart_break_tx.sv
module uart_break_tx
  import ubk_pkg::*;
#(
  parameter int GUARD_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitTick,
  input  logic                wrEn,
  input  logic [DATA_MAX-1:0] wrData,
  input  logic                brkStart,
  input  logic                brkStop,
  input  logic [1:0]          cfgDataSel,
  input  logic [1:0]          cfgParity,
  input  logic                cfgTwoStop,
  output logic                txd,
  output logic                txReady,
  output logic                txEmpty
);
  txCfg_t  cfg;
  dpCtrl_t ctl;
  dpStat_t stat;

  assign cfg.dataSel = cfgDataSel;
  assign cfg.parity  = cfgParity;
  assign cfg.twoStop = cfgTwoStop;

  ubk_ctrl #(.GUARD_BITS(GUARD_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .wrEn(wrEn),
    .cmdStart(brkStart), .cmdStop(brkStop), .cfg(cfg), .stat(stat),
    .ctl(ctl), .txReady(txReady), .txEmpty(txEmpty)
  );

  ubk_datapath u_dp (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .wrData(wrData),
    .cfg(cfg), .ctl(ctl), .stat(stat), .txd(txd)
  );
endmodule

// File: tb/tb_uart_break_tx.sv
`timescale 1ns/1ps
module tb_uart_break_tx;
  localparam int TDIV  = 4;
  localparam int LOGN  = 8192;
  localparam int GUARD = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic brkStart = 1'b0, brkStop = 1'b0;
  logic [1:0] cfgDataSel = 2'd3, cfgParity = 2'd0;
  logic cfgTwoStop = 1'b0;
  logic txd, txReady, txEmpty;

  logic bitLog [0:LOGN-1];
  int logIdx = 0;
  int divCnt = 0;
  int nChk = 0, nFail = 0;

  uart_break_tx dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .wrEn(wrEn), .wrData(wrData),
    .brkStart(brkStart), .brkStop(brkStop), .cfgDataSel(cfgDataSel),
    .cfgParity(cfgParity), .cfgTwoStop(cfgTwoStop),
    .txd(txd), .txReady(txReady), .txEmpty(txEmpty)
  );

  always #2.5 clk = ~clk;

  // strobe generator; logs the line level of each bit interval just before it ends
  always @(negedge clk) begin
    if (!rstN) begin
      divCnt = 0;
      bitTick = 1'b0;
    end else begin
      divCnt = (divCnt == TDIV-1) ? 0 : divCnt + 1;
      if (divCnt == 0) begin
        if (logIdx < LOGN) bitLog[logIdx] = txd;
        logIdx++;
        bitTick = 1'b1;
      end else bitTick = 1'b0;
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int findLow(input int from);
    for (int i = from; i < logIdx && i < LOGN; i++) if (bitLog[i] == 1'b0) return i;
    return -1;
  endfunction

  function automatic int runLen(input int from, input logic v);
    int r = 0;
    while (from + r < logIdx && from + r < LOGN && bitLog[from+r] == v) r++;
    return r;
  endfunction

  task automatic setCfg(input int ds, input int par, input int ts);
    @(negedge clk);
    cfgDataSel = 2'(ds); cfgParity = 2'(par); cfgTwoStop = 1'(ts);
  endtask

  task automatic pulseWr(input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic pulseCmd(input logic s, input logic p);
    @(negedge clk); brkStart = s; brkStop = p;
    @(negedge clk); brkStart = 1'b0; brkStop = 1'b0;
  endtask

  task automatic waitTicks(input int n);
    for (int k = 0; k < n; k++) begin
      do @(posedge clk); while (!bitTick);
    end
    @(negedge clk);
  endtask

  task automatic waitEmpty(input logic v, input string req);
    int c = 0;
    while (txEmpty !== v && c < 2000) begin @(negedge clk); c++; end
    chk(txEmpty === v, req, int'(txEmpty), int'(v));
  endtask

  task automatic waitReady(input logic v, input string req);
    int c = 0;
    while (txReady !== v && c < 2000) begin @(negedge clk); c++; end
    chk(txReady === v, req, int'(txReady), int'(v));
  endtask

  // decode one frame from the log and compare with the bench's own framing
  task automatic checkFrame(input int from, input int ds, input int par, input int ts,
                            input logic [7:0] d, input string req,
                            output int startIdx, output int nextIdx);
    logic expb [0:11];
    int n, len, ones, bad;
    n = 5 + ds; ones = 0; len = 0;
    expb[len++] = 1'b0;
    for (int i = 0; i < n; i++) begin expb[len++] = d[i]; if (d[i]) ones++; end
    if (par == 1) expb[len++] = 1'(ones % 2);
    else if (par == 2) expb[len++] = 1'((ones + 1) % 2);
    expb[len++] = 1'b1;
    if (ts != 0) expb[len++] = 1'b1;
    startIdx = findLow(from);
    bad = 0;
    if (startIdx < 0 || startIdx + len > logIdx) bad = 99;
    else for (int j = 0; j < len; j++) if (bitLog[startIdx+j] !== expb[j]) bad++;
    chk(bad == 0, req, bad, 0);
    nextIdx = startIdx + len;
  endtask

  int s0, s1, nx, nx2, idx, e, L;

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(txd === 1'b1, "R1 txd", int'(txd), 1);
    chk(txReady === 1'b1, "R1 ready", int'(txReady), 1);
    chk(txEmpty === 1'b1, "R1 empty", int'(txEmpty), 1);

    // R2 sweep over all framing codes
    for (int ds = 0; ds < 4; ds++)
      for (int par = 0; par < 4; par++)
        for (int ts = 0; ts < 2; ts++)
          for (int k = 0; k < 2; k++) begin
            logic [7:0] d;
            d = 8'((ds*37 + par*11 + ts*5 + k*90 + 19) & 255);
            setCfg(ds, par, ts);
            idx = logIdx;
            pulseWr(d);
            waitEmpty(1'b1, "R2 frame done");
            checkFrame(idx, ds, (par == 3) ? 0 : par, ts, d, "R2 frame", s0, nx);
          end

    // R2 back-to-back frames
    setCfg(3, 1, 0);
    idx = logIdx;
    pulseWr(8'hA7);
    waitReady(1'b1, "R2 hold drained");
    pulseWr(8'h5E);
    chk(txReady === 1'b0, "R2 second queued", int'(txReady), 0);
    waitEmpty(1'b1, "R2 pair done");
    checkFrame(idx, 3, 1, 0, 8'hA7, "R2 first", s0, nx);
    checkFrame(nx, 3, 1, 0, 8'h5E, "R2 second", s1, nx2);
    chk(s1 == nx, "R2 no gap", s1, nx);

    // R3 config change mid-frame
    setCfg(3, 2, 1);
    idx = logIdx;
    pulseWr(8'hC3);
    waitTicks(3);
    setCfg(0, 0, 0);
    waitEmpty(1'b1, "R3 done");
    checkFrame(idx, 3, 2, 1, 8'hC3, "R3 frame kept config", s0, nx);

    // R8 stop without break
    setCfg(3, 0, 0);
    idx = logIdx;
    pulseCmd(1'b0, 1'b1);
    chk(txReady === 1'b1 && txEmpty === 1'b1, "R8 flags", int'({txReady, txEmpty}), 3);
    waitTicks(15);
    chk(findLow(idx) == -1, "R8 line high", findLow(idx), -1);

    // R11 start and stop together
    idx = logIdx;
    pulseCmd(1'b1, 1'b1);
    chk(txReady === 1'b1, "R11 ready", int'(txReady), 1);
    waitTicks(15);
    chk(findLow(idx) == -1 && txEmpty === 1'b1, "R11 no break", findLow(idx), -1);

    // R5 R6 R7 break from idle, early stop, two frame sizes
    for (int v = 0; v < 2; v++) begin
      if (v == 0) begin setCfg(0, 0, 0); L = 7; end
      else begin setCfg(3, 2, 1); L = 12; end
      idx = logIdx;
      pulseCmd(1'b1, 1'b0);
      chk(txReady === 1'b0, "R5 ready drops", int'(txReady), 0);
      waitEmpty(1'b0, "R5 break begins");
      chk(txReady === 1'b1, "R5 ready back", int'(txReady), 1);
      pulseCmd(1'b0, 1'b1);
      waitEmpty(1'b1, "R7 end");
      s0 = findLow(idx);
      chk(runLen(s0, 1'b0) == L, "R6 low length", runLen(s0, 1'b0), L);
      chk(runLen(s0 + L, 1'b1) == GUARD, "R7 guard", runLen(s0 + L, 1'b1), GUARD);
      chk(logIdx == s0 + L + GUARD, "R7 empty timing", logIdx, s0 + L + GUARD);
    end

    // R5 break waits for a character in flight
    setCfg(3, 0, 0);
    idx = logIdx;
    pulseWr(8'h96);
    waitReady(1'b1, "R5 loaded");
    pulseCmd(1'b1, 1'b0);
    chk(txReady === 1'b0 && txEmpty === 1'b0, "R5 pending flags",
        int'({txReady, txEmpty}), 0);
    waitReady(1'b1, "R5 started");
    pulseCmd(1'b0, 1'b1);
    waitEmpty(1'b1, "R5 end");
    checkFrame(idx, 3, 0, 0, 8'h96, "R5 char completes", s0, nx);
    chk(runLen(nx, 1'b0) == 10, "R5 low after char", runLen(nx, 1'b0), 10);

    // R9 write while pending is discarded
    idx = logIdx;
    pulseWr(8'h21);
    waitReady(1'b1, "R9 loaded");
    pulseCmd(1'b1, 1'b0);
    pulseWr(8'h3C);
    waitReady(1'b1, "R9 started");
    pulseCmd(1'b0, 1'b1);
    waitEmpty(1'b1, "R9 end");
    e = logIdx;
    waitTicks(15);
    checkFrame(idx, 3, 0, 0, 8'h21, "R9 char", s0, nx);
    chk(findLow(e) == -1 && txEmpty === 1'b1, "R9 no extra frame", findLow(e), -1);

    // R10 writes during low time and guard are discarded
    idx = logIdx;
    pulseCmd(1'b1, 1'b0);
    waitEmpty(1'b0, "R10 began");
    chk(txReady === 1'b1, "R10 ready reads 1", int'(txReady), 1);
    pulseWr(8'h55);
    pulseCmd(1'b0, 1'b1);
    waitTicks(13);
    pulseWr(8'h0F);
    waitEmpty(1'b1, "R10 end");
    e = logIdx;
    waitTicks(15);
    s0 = findLow(idx);
    chk(runLen(s0, 1'b0) == 10, "R10 low", runLen(s0, 1'b0), 10);
    chk(findLow(e) == -1 && txEmpty === 1'b1, "R10 nothing sent", findLow(e), -1);

    // R12 repeated start during break and guard
    idx = logIdx;
    pulseCmd(1'b1, 1'b0);
    waitEmpty(1'b0, "R12 began");
    pulseCmd(1'b1, 1'b0);
    pulseCmd(1'b0, 1'b1);
    waitTicks(13);
    pulseCmd(1'b1, 1'b0);
    waitEmpty(1'b1, "R12 end");
    e = logIdx;
    waitTicks(20);
    s0 = findLow(idx);
    chk(runLen(s0, 1'b0) == 10, "R12 single low", runLen(s0, 1'b0), 10);
    chk(findLow(e) == -1 && txEmpty === 1'b1, "R12 no second break", findLow(e), -1);

    // R6 late stop
    idx = logIdx;
    pulseCmd(1'b1, 1'b0);
    waitEmpty(1'b0, "R6 began");
    waitTicks(20);
    chk(txd === 1'b0 && txEmpty === 1'b0, "R6 held low", int'(txd), 0);
    pulseCmd(1'b0, 1'b1);
    waitEmpty(1'b1, "R6 end");
    s0 = findLow(idx);
    chk(runLen(s0, 1'b0) == 21, "R6 late low", runLen(s0, 1'b0), 21);
    chk(runLen(s0 + 21, 1'b1) == GUARD, "R7 late guard", runLen(s0 + 21, 1'b1), GUARD);

    // normal traffic resumes after a break
    idx = logIdx;
    pulseWr(8'h6B);
    waitEmpty(1'b1, "R2 after break");
    checkFrame(idx, 3, 0, 0, 8'h6B, "R2 resume", s0, nx);

    report();
  end
endmodule